// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small, fully associative cache of branches that are expected to be taken. The fetch unit presents the address it is fetching. If that address matches a stored branch address, the block reports a hit. It also returns the stored destination as the next fetch address in the same cycle, before the instruction has been decoded. If nothing matches, the block returns the sequential address, which is the fetch address plus 4. A tag match alone marks the instruction as a taken branch, so the table holds only branches that are predicted taken.

When a branch resolves later in the pipeline, the back end reports it on the update port. The report carries the branch address, its outcome, its real target and the next address that was predicted for it at fetch. The block flags a mispredict when the real next address differs from the predicted one. It then maintains the table:
- A taken branch that is missing from the table is added.
- A stored branch that falls through is removed.
- A stored branch that jumps somewhere else gets its target rewritten.

Free entries are used lowest index first. When the table is full, a round-robin pointer chooses the entry to evict.

Top module: `btb_top`

## Requirements
- R1: After reset every entry is empty, so no fetch address hits.
- R2: When the fetch address matches no valid entry, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`, modulo 2^ADDR_W.
- R3: A taken update whose branch address is not in the table installs that address with `upd_target`. From the next cycle on, fetching that address gives `pred_hit` = 1 and `pred_next_pc` = `upd_target`.
- R4: A not-taken update whose branch address is in the table removes it. From the next cycle on, that address misses.
- R5: A taken update whose branch address is in the table with a different target replaces the stored target in place. No second copy of the address is created, and no other entry changes.
- R6: When a taken update must install while every entry is valid, it evicts the entry at the round-robin pointer. The pointer starts at entry 0 after reset, moves by one after each such eviction, and wraps from N_ENTRIES-1 to 0.
- R7: When at least one entry is free, an install takes the lowest-indexed free entry, evicts nothing and leaves the pointer unchanged.
- R8: `upd_mispredict` is 1 exactly when `upd_valid` is 1 and the resolved next address differs from `upd_pred_next`. The resolved next address is `upd_target` if `upd_taken` is 1, else `upd_pc + 4`.
- R9: Updates take effect at the clock edge. A fetch lookup in the same cycle as an update sees the table contents from before that update.
- R10: A not-taken update for an address that is not in the table changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_hit | output | 1 | Fetch address found; treat as taken branch |
| pred_next_pc | output | ADDR_W | Next fetch address (stored target or fetch_pc + 4) |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | ADDR_W | Resolved destination when taken |
| upd_pred_next | input | ADDR_W | Next address that was predicted at fetch for this branch |
| upd_mispredict | output | 1 | Resolved next address differs from the prediction |

## Verification
The bench builds the buffer with 4 entries and 8-bit addresses. At that size all 256 fetch addresses can be swept after every update and compared with a model of the requirements. That sweep covers the wrap of the sequential address at the top of the space. Four installs fill the table, so the eviction order, the pointer advancing, and the reuse of a freed slot ahead of eviction are all reached within a few dozen updates.

// File: rtl/btb_pkg.sv
// Package: shared constants and types for the branch target buffer.
// Assumes a fixed 4-byte instruction size for the sequential next address.
package btb_pkg;

    // Byte distance from one instruction to the next one fetched in sequence.
    localparam int unsigned BTB_STEP = 4;

    // Table maintenance decided for one reported branch.
    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_INSTALL  = 2'd1,
        UPD_RETARGET = 2'd2,
        UPD_DROP     = 2'd3
    } btb_upd_e;

endpackage

// File: rtl/btb_entry.sv
// Module: one table entry holding a valid flag, a full branch address and a
// predicted destination. It compares its address with the fetch port and with
// the update port at the same time.
// Assumes at most one of install/retarget/drop is asserted in any cycle.
module btb_entry #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              install_en,
    input  logic              retarget_en,
    input  logic              drop_en,
    input  logic [ADDR_W-1:0] new_target,
    output logic              valid_o,
    output logic              fetch_hit_o,
    output logic              upd_hit_o,
    output logic [ADDR_W-1:0] target_o
);

    logic              valid_q;
    logic [ADDR_W-1:0] tag_q;
    logic [ADDR_W-1:0] target_q;

    // Valid flag: set on install, cleared on drop and at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (install_en) begin
            valid_q <= 1'b1;
        end else if (drop_en) begin
            valid_q <= 1'b0;
        end
    end

    // Branch address: captured only when the entry is (re)installed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (install_en) begin
            tag_q <= upd_pc;
        end
    end

    // Destination: written on install and on a target correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (install_en || retarget_en) begin
            target_q <= new_target;
        end
    end

    // Compare the stored address with both ports.
    always_comb begin
        fetch_hit_o = valid_q && (tag_q == fetch_pc);
        upd_hit_o   = valid_q && (tag_q == upd_pc);
    end

    assign valid_o  = valid_q;
    assign target_o = target_q;

endmodule

// File: rtl/btb_onehot_mux.sv
// Module: selects one word out of a packed array using a one-hot (or all-zero)
// select vector. An all-zero select gives zero.
// Assumes the select has at most one bit set.
module btb_onehot_mux #(
    parameter int unsigned N_WAYS = 4,
    parameter int unsigned WIDTH  = 32
) (
    input  logic [N_WAYS-1:0]            sel,
    input  logic [N_WAYS-1:0][WIDTH-1:0] data,
    output logic [WIDTH-1:0]             out
);

    // OR together the words whose select bit is set.
    always_comb begin
        out = '0;
        for (int i = 0; i < N_WAYS; i++) begin
            if (sel[i]) begin
                out = out | data[i];
            end
        end
    end

endmodule

// File: rtl/btb_alloc.sv
// Module: picks the entry that receives a new branch. The lowest-indexed free
// entry wins. With no free entry, a round-robin pointer names the victim, and
// the pointer moves on only when it was actually used.
// Assumes alloc_req is raised only when an install really happens.
module btb_alloc #(
    parameter int unsigned N_ENTRIES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] valid_vec,
    input  logic                 alloc_req,
    output logic [N_ENTRIES-1:0] alloc_oh
);

    localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Find the lowest-indexed entry that is not valid.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // One-hot target: free slot if there is one, else the pointer's slot.
    always_comb begin
        alloc_oh = '0;
        if (any_free) begin
            alloc_oh[free_idx] = 1'b1;
        end else begin
            alloc_oh[rr_ptr_q] = 1'b1;
        end
    end

    // Move the round-robin pointer after each eviction, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (alloc_req && !any_free) begin
            rr_ptr_q <= (rr_ptr_q == LAST_IDX) ? '0 : rr_ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/btb_top.sv
// Module: fully associative branch target buffer. The lookup is combinational
// on fetch_pc. Table maintenance comes from resolved branches and lands at the
// next clock edge.
// Assumes one resolved branch at most per cycle, and that upd_pred_next is the
// next address that this block supplied when that branch was fetched.
module btb_top
    import btb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned N_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_next_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic [ADDR_W-1:0] upd_pred_next,
    output logic              upd_mispredict
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BTB_STEP);

    logic [N_ENTRIES-1:0]             valid_vec;
    logic [N_ENTRIES-1:0]             fetch_match;
    logic [N_ENTRIES-1:0]             upd_match;
    logic [N_ENTRIES-1:0]             alloc_oh;
    logic [N_ENTRIES-1:0][ADDR_W-1:0] target_arr;
    logic [ADDR_W-1:0]                fetch_target;
    logic [ADDR_W-1:0]                upd_old_target;
    logic                             upd_hit;
    logic [ADDR_W-1:0]                resolved_next;
    btb_upd_e                         upd_action;

    // One storage entry per way.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        btb_entry #(
            .ADDR_W (ADDR_W)
        ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .fetch_pc    (fetch_pc),
            .upd_pc      (upd_pc),
            .install_en  ((upd_action == UPD_INSTALL) && alloc_oh[g]),
            .retarget_en ((upd_action == UPD_RETARGET) && upd_match[g]),
            .drop_en     ((upd_action == UPD_DROP) && upd_match[g]),
            .new_target  (upd_target),
            .valid_o     (valid_vec[g]),
            .fetch_hit_o (fetch_match[g]),
            .upd_hit_o   (upd_match[g]),
            .target_o    (target_arr[g])
        );
    end

    btb_onehot_mux #(
        .N_WAYS (N_ENTRIES),
        .WIDTH  (ADDR_W)
    ) u_fetch_mux (
        .sel  (fetch_match),
        .data (target_arr),
        .out  (fetch_target)
    );

    btb_onehot_mux #(
        .N_WAYS (N_ENTRIES),
        .WIDTH  (ADDR_W)
    ) u_upd_mux (
        .sel  (upd_match),
        .data (target_arr),
        .out  (upd_old_target)
    );

    btb_alloc #(
        .N_ENTRIES (N_ENTRIES)
    ) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .alloc_req (upd_action == UPD_INSTALL),
        .alloc_oh  (alloc_oh)
    );

    // Fetch prediction: stored target on a hit, sequential address otherwise.
    always_comb begin
        pred_hit     = |fetch_match;
        pred_next_pc = pred_hit ? fetch_target : fetch_pc + STEP;
    end

    // Decide the table action for the reported branch.
    always_comb begin
        upd_hit    = |upd_match;
        upd_action = UPD_NONE;
        if (upd_valid) begin
            if (upd_hit) begin
                if (!upd_taken) begin
                    upd_action = UPD_DROP;
                end else if (upd_old_target != upd_target) begin
                    upd_action = UPD_RETARGET;
                end
            end else if (upd_taken) begin
                upd_action = UPD_INSTALL;
            end
        end
    end

    // Compare the real next address with the one predicted at fetch.
    always_comb begin
        resolved_next  = upd_taken ? upd_target : upd_pc + STEP;
        upd_mispredict = upd_valid && (resolved_next != upd_pred_next);
    end

endmodule

// File: rtl/btb_checker.sv
// Module: property checker for btb_top, attached with bind. It observes ports
// and the per-entry match vector that the entries drive.
// Assumes the 4-byte sequential step from btb_pkg.
module btb_checker
    import btb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned N_ENTRIES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    fetch_pc,
    input logic                 pred_hit,
    input logic [ADDR_W-1:0]    pred_next_pc,
    input logic                 upd_valid,
    input logic [ADDR_W-1:0]    upd_pc,
    input logic                 upd_taken,
    input logic [ADDR_W-1:0]    upd_target,
    input logic [ADDR_W-1:0]    upd_pred_next,
    input logic                 upd_mispredict,
    input logic [N_ENTRIES-1:0] fetch_match
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BTB_STEP);

    // R1: first cycle out of reset sees an empty table.
    p_empty_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !pred_hit);

    // R2: a miss predicts the sequential address.
    p_miss_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_next_pc == fetch_pc + STEP));

    // R3: a taken branch is found with its target in the following cycle.
    p_taken_installed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            ((fetch_pc != $past(upd_pc)) ||
             (pred_hit && (pred_next_pc == $past(upd_target)))));

    // R4: a not-taken branch is absent in the following cycle.
    p_fallthrough_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=>
            ((fetch_pc != $past(upd_pc)) || !pred_hit));

    // R5: an address is never stored in two entries.
    p_single_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_match));

    // R8: a wrong taken target is always flagged, and nothing without an update.
    p_wrong_target_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && (upd_pred_next != upd_target)) |-> upd_mispredict);

    p_quiet_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> !upd_mispredict);

endmodule

bind btb_top btb_checker #(
    .ADDR_W    (ADDR_W),
    .N_ENTRIES (N_ENTRIES)
) u_btb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .pred_hit       (pred_hit),
    .pred_next_pc   (pred_next_pc),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .upd_taken      (upd_taken),
    .upd_target     (upd_target),
    .upd_pred_next  (upd_pred_next),
    .upd_mispredict (upd_mispredict),
    .fetch_match    (fetch_match)
);

// File: tb/test_btb_top.sv
`timescale 1ns/1ps
// Bench: 4-entry, 8-bit address build. A table model computed from the
// requirements is compared over all 256 fetch addresses after each update.
module test_btb_top;

    localparam int AW = 8;
    localparam int N  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_hit;
    logic [AW-1:0] pred_next_pc;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;
    logic [AW-1:0] upd_pred_next = '0;
    logic          upd_mispredict;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Requirement model.
    logic          m_v  [N];
    logic [AW-1:0] m_pc [N];
    logic [AW-1:0] m_tg [N];
    int            m_ptr;

    btb_top #(.ADDR_W(AW), .N_ENTRIES(N)) i_btb_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .pred_hit       (pred_hit),
        .pred_next_pc   (pred_next_pc),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_target     (upd_target),
        .upd_pred_next  (upd_pred_next),
        .upd_mispredict (upd_mispredict)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [AW-1:0] pc);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_pc[i] == pc) return i;
        end
        return -1;
    endfunction

    // Compare hit and next address for the current fetch_pc against the model.
    task automatic chk_fetch(input string req);
        int k;
        logic [AW-1:0] exp_next;
        k = m_find(fetch_pc);
        exp_next = (k >= 0) ? m_tg[k] : fetch_pc + AW'(4);
        chk(pred_hit == (k >= 0), req, "hit", int'(pred_hit), int'(k >= 0));
        chk(pred_next_pc == exp_next, req, "next_pc", int'(pred_next_pc), int'(exp_next));
    endtask

    // Sweep every fetch address with no update pending.
    task automatic sweep(input string req);
        for (int p = 0; p < 256; p++) begin
            fetch_pc = AW'(p);
            #0.1;
            chk_fetch(req);
        end
    endtask

    // Apply the table rules of R3..R7 and R10 to the model.
    task automatic m_apply(input logic [AW-1:0] pc, input logic tk,
                           input logic [AW-1:0] tg);
        int k;
        int f;
        k = m_find(pc);
        if (k >= 0) begin
            if (!tk) m_v[k] = 1'b0;
            else m_tg[k] = tg;
        end else if (tk) begin
            f = -1;
            for (int i = N - 1; i >= 0; i--) begin
                if (!m_v[i]) f = i;
            end
            if (f < 0) begin
                f = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            m_v[f] = 1'b1;
            m_pc[f] = pc;
            m_tg[f] = tg;
        end
    endtask

    // One resolved branch: checks mispredict and the same-cycle lookup (R9).
    task automatic resolve(input logic [AW-1:0] pc, input logic tk,
                           input logic [AW-1:0] tg, input logic [AW-1:0] pr,
                           input string req);
        logic [AW-1:0] res;
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = tk;
        upd_target = tg;
        upd_pred_next = pr;
        fetch_pc = pc;
        #1;
        res = tk ? tg : pc + AW'(4);
        chk(upd_mispredict == (res != pr), "R8", req,
            int'(upd_mispredict), int'(res != pr));
        chk_fetch("R9");
        @(posedge clk);
        m_apply(pc, tk, tg);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        chk(upd_mispredict == 1'b0, "R8", "idle flag", int'(upd_mispredict), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0;
            m_pc[i] = '0;
            m_tg[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        sweep("R1");                                   // R1 and R2 miss path
        resolve(8'h10, 1'b1, 8'h40, 8'h14, "install A"); sweep("R3");
        resolve(8'h10, 1'b1, 8'h80, 8'h40, "retarget A"); sweep("R5");
        resolve(8'h10, 1'b1, 8'h80, 8'h80, "correct A"); sweep("R5");
        resolve(8'h20, 1'b0, 8'h00, 8'h24, "absent nt"); sweep("R10");
        resolve(8'h20, 1'b0, 8'h00, 8'h30, "nt bad pred"); sweep("R10");
        resolve(8'h11, 1'b1, 8'h70, 8'h15, "install B"); sweep("R7");
        resolve(8'hFC, 1'b1, 8'h08, 8'h00, "install C"); sweep("R7");
        resolve(8'h33, 1'b1, 8'h33, 8'h37, "install D"); sweep("R7");
        resolve(8'h44, 1'b1, 8'h50, 8'h48, "evict slot0"); sweep("R6");
        chk(pred_hit == 1'b0 || fetch_pc != 8'h10, "R6", "A gone", int'(pred_hit), 0);
        resolve(8'h55, 1'b1, 8'h60, 8'h59, "evict slot1"); sweep("R6");
        resolve(8'hFC, 1'b0, 8'h00, 8'h08, "drop C"); sweep("R4");
        resolve(8'h66, 1'b1, 8'h01, 8'h6A, "reuse slot2"); sweep("R7");
        resolve(8'h77, 1'b1, 8'h02, 8'h7B, "evict slot2"); sweep("R6");
        resolve(8'h88, 1'b1, 8'h03, 8'h8C, "evict slot3"); sweep("R6");
        resolve(8'h99, 1'b1, 8'h04, 8'h9D, "wrap to slot0"); sweep("R6");
        resolve(8'h99, 1'b1, 8'h05, 8'h04, "retarget full"); sweep("R5");
        resolve(8'hAA, 1'b0, 8'h00, 8'hAE, "absent nt full"); sweep("R10");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_ptr = 0;
        #1;
        sweep("R1");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule